// File: doc/BRIEF.md
# Multidrop TDM Slot Transmitter

This block places four capture channels of 24-bit audio onto one shared serial data wire that is split into time slots. Each channel has its own enable and a 6-bit start position, counted in groups of eight bit periods from the start of the frame. Several copies of the block can therefore sit on the same wire, each filling its own slots. The block drives the wire only during the bit periods it owns. In every other bit period its output-enable is low, so the pad stays at high impedance and another device can drive the line.

The bit clock and the frame sync arrive as levels sampled by a faster system clock, and the block acts on their transitions. An inversion control chooses which bit-clock edge the receiver samples on. The other edge then launches data. An early-launch control moves each launch half a bit period earlier, onto the sampling edge, so that a device can hand the line to the next device within half a bit period. Samples are written into a holding register with a valid strobe. The whole set is copied into the frame register at the frame start. The bit clock may stop once the useful bits of a frame have been sent, and the block holds its state until the clock starts again.

Top module: `tdm_slot_tx`

## Requirements
- R1: After reset, and until the first bit-clock transition, `sd_oe` and `sd_o` are both 0.
- R2: A frame starts at a capture edge. Bit index 0 of the frame is the first bit launched from that frame start. Channel c starts at bit index `tx_loc[c*6 +: 6] * 8`.
- R3: Channel c occupies 24 consecutive bit indices, MSB first. Bit index start+k carries sample bit 23-k, where the channel's sample is `sample_in[c*24 +: 24]`.
- R4: `sd_oe` is 1 only during bit indices owned by an enabled channel. It falls at the launch that follows a channel's last bit. `sd_o` is 0 whenever `sd_oe` is 0.
- R5: A channel whose `tx_en[c]` is 0 never causes `sd_oe` to be set.
- R6: When the slots of two enabled channels overlap, the lower-numbered channel drives the shared bit indices.
- R7: `sample_vld` loads `sample_in` into a holding register. Each frame transmits the set that was held at its frame start. A load in the middle of a frame first appears in the next frame.
- R8: With `sclk_inv`=0 the capture edge is the rising edge of `sclk` and data launches on the falling edge. With `sclk_inv`=1 the two roles are swapped.
- R9: With `early_launch`=1, data launches on capture edges, half a bit period earlier than normal. Bit index 0 goes out at the frame-start capture edge itself.
- R10: A frame start is a capture edge at which `fsync` is 1 and at which `fsync` was 0 at the previous capture edge. If `fsync` stays high, no new frame starts.
- R11: While `sclk` does not toggle, the outputs and the frame position hold. When `sclk` resumes, transmission continues at the next bit.
- R12: The outputs change only at launch edges. With `early_launch`=0, a capture edge leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bit clock and frame sync |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Bit-clock level, synchronous to clk |
| fsync | input | 1 | Frame-sync level, synchronous to clk |
| sample_in | input | 96 | Four 24-bit samples, channel c at bits c*24 +: 24 |
| sample_vld | input | 1 | Loads sample_in into the holding register |
| tx_en | input | 4 | Per-channel transmit enable |
| tx_loc | input | 24 | Per-channel 6-bit start position, in units of 8 bit periods |
| sclk_inv | input | 1 | Swaps the capture and launch edges of sclk |
| early_launch | input | 1 | Launches data on the capture edge |
| sd_o | output | 1 | Serial data bit |
| sd_oe | output | 1 | Drive enable for the shared data line |

## Verification
The assertions assume three things about the inputs. First, `sclk` and `fsync` are levels synchronous to `clk`, and each level is held for several `clk` cycles. Second, `tx_en`, `tx_loc`, `sclk_inv` and `early_launch` change only while the line is idle. Third, `sample_vld` never coincides with a frame start. The stimulus holds each bit-clock half for three system cycles, changes the configuration between frames after a settling transition, and pulses `sample_vld` only between bit-clock transitions. Random frames vary the enables, start positions, edge polarity, launch timing and sample values.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    localparam int CH_N      = 4;
    localparam int WORD_W    = 24;
    localparam int LOC_BITS  = 6;
    localparam int SLOT_UNIT = 8;

    // Events recovered from the sampled bit clock and frame sync
    typedef struct packed {
        logic cap;    // capture edge of sclk
        logic lau;    // launch edge of sclk
        logic start;  // capture edge that opens a frame
    } tdm_ev_t;

endpackage

// File: rtl/tdm_edge_det.sv
module tdm_edge_det
    import tdm_tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sclk,
    input  logic    fsync,
    input  logic    inv,
    output tdm_ev_t ev
);

    typedef struct packed {
        logic lvl;  // sclk level at the previous clk edge
        logic fs;   // fsync level at the previous capture edge
    } edge_st_t;

    edge_st_t q, d;
    logic     flip;

    assign flip = (sclk != q.lvl);

    always_comb begin
        ev.cap   = flip && (sclk != inv);
        ev.lau   = flip && (sclk == inv);
        ev.start = ev.cap && fsync && !q.fs;
        d        = q;
        d.lvl    = sclk;
        if (ev.cap) begin
            d.fs = fsync;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map #(
    parameter int NCH   = 4,
    parameter int WORD  = 24,
    parameter int LOC_W = 6,
    parameter int UNIT  = 8,
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0]      idx,
    input  logic [NCH-1:0]        en,
    input  logic [NCH*LOC_W-1:0]  loc,
    input  logic [NCH*WORD-1:0]   data,
    output logic                  own,
    output logic                  bit_o
);

    localparam int POS_W = $clog2(WORD);

    logic [NCH-1:0] hit;
    logic [NCH-1:0] hbit;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [CNT_W-1:0] st;
        logic [CNT_W-1:0] off;
        logic [WORD-1:0]  w;
        logic [POS_W-1:0] pos;

        assign st      = CNT_W'(loc[c*LOC_W +: LOC_W]) * CNT_W'(UNIT);
        assign off     = idx - st;
        assign w       = data[c*WORD +: WORD];
        assign pos     = POS_W'(WORD - 1) - off[POS_W-1:0];
        assign hit[c]  = en[c] && (idx >= st) && (off < CNT_W'(WORD));
        assign hbit[c] = w[pos];
    end

    // lowest-numbered channel takes priority
    always_comb begin
        own   = |hit;
        bit_o = 1'b0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (hit[c]) begin
                bit_o = hbit[c];
            end
        end
    end

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
    import tdm_tx_pkg::*;
#(
    parameter int NCH   = CH_N,
    parameter int WORD  = WORD_W,
    parameter int LOC_W = LOC_BITS,
    parameter int UNIT  = SLOT_UNIT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk,
    input  logic                 fsync,
    input  logic [NCH*WORD-1:0]  sample_in,
    input  logic                 sample_vld,
    input  logic [NCH-1:0]       tx_en,
    input  logic [NCH*LOC_W-1:0] tx_loc,
    input  logic                 sclk_inv,
    input  logic                 early_launch,
    output logic                 sd_o,
    output logic                 sd_oe
);

    // bit index past every possible slot; the counter parks here
    localparam int LIMIT = (2 ** LOC_W) * UNIT + WORD;
    localparam int CNT_W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [NCH*WORD-1:0] hold;
        logic [NCH*WORD-1:0] frame;
        logic [CNT_W-1:0]    cnt;
        logic                sd;
        logic                oe;
    } tx_st_t;

    tx_st_t              q, d;
    tdm_ev_t             ev;
    logic                launch;
    logic [CNT_W-1:0]    idx;
    logic [NCH*WORD-1:0] src;
    logic                own;
    logic                bit_v;

    tdm_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .fsync (fsync),
        .inv   (sclk_inv),
        .ev    (ev)
    );

    assign launch = early_launch ? ev.cap : ev.lau;
    assign idx    = ev.start ? '0 : q.cnt;
    assign src    = ev.start ? q.hold : q.frame;

    tdm_slot_map #(
        .NCH   (NCH),
        .WORD  (WORD),
        .LOC_W (LOC_W),
        .UNIT  (UNIT),
        .CNT_W (CNT_W)
    ) u_map (
        .idx   (idx),
        .en    (tx_en),
        .loc   (tx_loc),
        .data  (src),
        .own   (own),
        .bit_o (bit_v)
    );

    always_comb begin
        d = q;
        if (sample_vld) begin
            d.hold = sample_in;
        end
        if (ev.start) begin
            d.frame = q.hold;
            d.cnt   = early_launch ? CNT_W'(1) : '0;
        end
        if (launch) begin
            d.oe = own;
            d.sd = own & bit_v;
            if (!ev.start) begin
                d.cnt = (q.cnt == CNT_W'(LIMIT)) ? q.cnt : q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.hold  <= '0;
            q.frame <= '0;
            q.cnt   <= CNT_W'(LIMIT);
            q.sd    <= 1'b0;
            q.oe    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sd_o  = q.sd;
    assign sd_oe = q.oe;

endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sclk,
    input logic [NCH-1:0] tx_en,
    input logic           sd_o,
    input logic           sd_oe
);

    logic sclk_p;
    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p <= 1'b0;
            seen   <= 1'b0;
        end else begin
            sclk_p <= sclk;
            if (sclk != sclk_p) begin
                seen <= 1'b1;
            end
        end
    end

    // R1
    idle_before_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (!sd_oe && !sd_o));

    // R12
    hold_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk == sclk_p) |=> ($stable(sd_o) && $stable(sd_oe)));

    // R5
    no_drive_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sclk != sclk_p) && (tx_en == '0)) |=> !sd_oe);

    // R4
    parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> !sd_o);

endmodule

bind tdm_slot_tx tdm_slot_tx_chk #(.NCH(NCH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (sclk),
    .tx_en (tx_en),
    .sd_o  (sd_o),
    .sd_oe (sd_oe)
);

// File: tb/tdm_slot_tx_test.sv
module tdm_slot_tx_test;

    localparam int NCH   = 4;
    localparam int WORD  = 24;
    localparam int LOC_W = 6;
    localparam int UNIT  = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sclk = 1'b0;
    logic                 fsync = 1'b0;
    logic [NCH*WORD-1:0]  sample_in = '0;
    logic                 sample_vld = 1'b0;
    logic [NCH-1:0]       tx_en = '0;
    logic [NCH*LOC_W-1:0] tx_loc = '0;
    logic                 sclk_inv = 1'b0;
    logic                 early_launch = 1'b0;
    logic                 sd_o;
    logic                 sd_oe;

    tdm_slot_tx uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk         (sclk),
        .fsync        (fsync),
        .sample_in    (sample_in),
        .sample_vld   (sample_vld),
        .tx_en        (tx_en),
        .tx_loc       (tx_loc),
        .sclk_inv     (sclk_inv),
        .early_launch (early_launch),
        .sd_o         (sd_o),
        .sd_oe        (sd_oe)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [WORD-1:0] pend [NCH];
    logic [WORD-1:0] cur  [NCH];
    int              loc_b [NCH];
    logic [NCH-1:0]  en_b;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc == 190000);
        fails++;
        $display("FAIL watchdog: run hung, act=%0d cycles exp<190000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    task automatic chk(string req, logic eo, logic ed);
        checks++;
        if (sd_oe !== eo || sd_o !== (eo ? ed : 1'b0)) begin
            fails++;
            $display("FAIL %s: act oe=%b d=%b exp oe=%b d=%b (t=%0t)",
                     req, sd_oe, sd_o, eo, eo ? ed : 1'b0, $time);
        end
    endtask

    // expected {oe, data} for one frame bit index
    function automatic logic [1:0] model(int idx);
        for (int c = 0; c < NCH; c++) begin
            int st = loc_b[c] * UNIT;
            if (en_b[c] && idx >= st && idx < st + WORD)
                return {1'b1, cur[c][WORD-1-(idx-st)]};
        end
        return 2'b00;
    endfunction

    task automatic load_samples();
        @(negedge clk);
        for (int c = 0; c < NCH; c++) sample_in[c*WORD +: WORD] = pend[c];
        sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
    endtask

    task automatic rand_samples();
        for (int c = 0; c < NCH; c++) pend[c] = WORD'($urandom);
    endtask

    task automatic half(logic lvl, logic fs);
        @(negedge clk);
        sclk  = lvl;
        fsync = fs;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cfg(logic inv, logic early, logic [NCH-1:0] en,
                       int l0, int l1, int l2, int l3);
        @(negedge clk);
        sclk_inv     = inv;
        early_launch = early;
        half(inv, 1'b0);
        loc_b[0] = l0; loc_b[1] = l1; loc_b[2] = l2; loc_b[3] = l3;
        en_b = en;
        tx_en = en;
        for (int c = 0; c < NCH; c++) tx_loc[c*LOC_W +: LOC_W] = LOC_W'(loc_b[c]);
        @(negedge clk);
    endtask

    task automatic run_frame(string req, int upd_at, int pause_at, int fs_len);
        int   nb = 2;
        logic po, pe;
        logic [1:0] m;
        for (int c = 0; c < NCH; c++)
            if (loc_b[c] * UNIT + WORD + 2 > nb) nb = loc_b[c] * UNIT + WORD + 2;
        for (int p = 0; p < nb; p++) begin
            if (p == upd_at) begin
                rand_samples();
                load_samples();
            end
            if (p == pause_at) begin
                po = sd_o;
                pe = sd_oe;
                for (int k = 0; k < 4; k++) begin
                    repeat (10) @(negedge clk);
                    chk("R11", pe, po);
                end
            end
            if (p == 0) for (int c = 0; c < NCH; c++) cur[c] = pend[c];
            po = sd_o;
            pe = sd_oe;
            half(~sclk_inv, p < fs_len);
            if (early_launch) begin
                m = model(p);
                chk(req, m[1], m[0]);
            end else begin
                chk("R12", pe, po);
            end
            half(sclk_inv, p < fs_len);
            if (!early_launch) begin
                m = model(p);
                chk(req, m[1], m[0]);
            end
        end
        fsync = 1'b0;
        repeat (5) @(negedge clk);
        chk(req, 1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < NCH; c++) begin
            pend[c] = '0; cur[c] = '0; loc_b[c] = 0;
        end
        en_b = '0;

        // R1: reset state, then idle after release
        repeat (4) @(negedge clk);
        chk("R1", 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", 1'b0, 1'b0);

        // R3: back-to-back slots, MSB-first bit order
        pend[0] = 24'hA5C381; pend[1] = 24'h800001;
        pend[2] = 24'h7FFFFE; pend[3] = 24'h0F0F0F;
        load_samples();
        cfg(1'b0, 1'b0, 4'b1111, 0, 3, 6, 9);
        run_frame("R3", -1, -1, 1);

        // R2: scattered start positions, including the last one
        rand_samples(); load_samples();
        cfg(1'b0, 1'b0, 4'b1111, 7, 1, 12, 63);
        run_frame("R2", -1, -1, 1);

        // R5: some channels disabled, then all disabled
        rand_samples(); load_samples();
        cfg(1'b0, 1'b0, 4'b0101, 2, 0, 5, 8);
        run_frame("R5", -1, -1, 1);
        cfg(1'b0, 1'b0, 4'b0000, 0, 3, 6, 9);
        run_frame("R5", -1, -1, 1);

        // R6: overlapping slots, lower channel wins
        rand_samples(); load_samples();
        cfg(1'b0, 1'b0, 4'b1111, 2, 3, 2, 1);
        run_frame("R6", -1, -1, 1);

        // R8: inverted bit clock
        rand_samples(); load_samples();
        cfg(1'b1, 1'b0, 4'b1011, 4, 0, 9, 1);
        run_frame("R8", -1, -1, 1);

        // R9: early launch, both polarities
        rand_samples(); load_samples();
        cfg(1'b0, 1'b1, 4'b1111, 0, 3, 6, 9);
        run_frame("R9", -1, -1, 1);
        rand_samples(); load_samples();
        cfg(1'b1, 1'b1, 4'b0111, 5, 0, 2, 3);
        run_frame("R9", -1, -1, 1);

        // R7: new samples loaded mid-frame wait for the next frame
        rand_samples(); load_samples();
        cfg(1'b0, 1'b0, 4'b1111, 0, 3, 6, 9);
        run_frame("R7", 10, -1, 1);
        run_frame("R7", -1, -1, 1);

        // R11: bit clock stopped inside an owned slot
        rand_samples(); load_samples();
        cfg(1'b0, 1'b0, 4'b0011, 0, 2, 0, 0);
        run_frame("R11", -1, 12, 1);

        // R10: fsync held high across three capture edges
        rand_samples(); load_samples();
        cfg(1'b0, 1'b0, 4'b1100, 0, 0, 0, 4);
        run_frame("R10", -1, -1, 3);

        // R4: random configurations and data
        for (int f = 0; f < 12; f++) begin
            rand_samples(); load_samples();
            cfg(1'($urandom), 1'($urandom), NCH'($urandom),
                int'($urandom % 64), int'($urandom % 64),
                int'($urandom % 64), int'($urandom % 64));
            run_frame("R4", -1, ($urandom % 4 == 0) ? 20 : -1, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule